// File: doc/BRIEF.md
# Watchdog Timer with Timed Disable

This block is a supervisory timer for a small microcontroller. Software drives it through one control byte that holds a run bit, a disarm-window bit and a three-bit period select. While the run bit is set, the block counts prescaled clock ticks. When the selected period runs out, it raises a one-cycle system reset request. Software keeps the device out of reset by pulsing a kick strobe before the period ends. The kick strobe zeroes the count.

The block guards against being switched off by accident. A write that clears the run bit only takes effect while a short disarm window is open. Software opens the window by writing the run bit and the window bit as ones in the same write. The hardware then closes the window by itself a fixed number of cycles later. A stray write of zero to the run bit at any other time changes nothing.

Top module: `wdt_core`

## Requirements
- R1: After reset the control byte reads 0x00 and reset_req is low.
- R2: Control byte layout: bits [2:0] are the period select, bit 3 is the run bit, bit 4 is the disarm-window flag (read only, set by hardware) and bits [7:5] read as zero.
- R3: The period for select value s is PRESCALE_DIV * 2^(s+BASE_EXP) clock cycles. This is the number of rising edges from the clearing edge to the edge after which reset_req is high. reset_req stays high for exactly one cycle.
- R4: After a timeout the count restarts from zero, so the next request follows one full period later when no kick arrives.
- R5: A kick strobe sampled high clears the count and the prescaler, and no request appears in the cycle after it.
- R6: A write that sets the run bit while the block is stopped starts the count from zero.
- R7: A write with bit 3 = 0 while the window is closed leaves the run bit unchanged.
- R8: A write with bits 3 and 4 both set opens the window. The window flag reads 1 for UNLOCK_CYCLES cycles after that write edge, and then the hardware clears it.
- R9: A write with bit 3 = 0 on any of the UNLOCK_CYCLES edges after the opening write stops the block. The same write one edge later is ignored.
- R10: A write with bit 4 = 1 and bit 3 = 0 neither opens the window nor stops the block.
- R11: While the run bit is 0, reset_req stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| kick | input | 1 | One-cycle strobe that clears the count |
| ctl_rdata | output | 8 | Control byte read value |
| reset_req | output | 1 | One-cycle system reset request on timeout |

## Verification
The bench builds the block with BASE_EXP = 2, PRESCALE_DIV = 2 and UNLOCK_CYCLES = 4. With these values the shortest period is 8 cycles and the longest (select 7) is 1024 cycles. Every period, including the longest, can therefore be measured edge by edge, both from a clearing event and across a restart. The window length keeps its default, so the bench can probe the first edge of the window, the last edge inside it, and the first edge after it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int SEL_W = 3;

    // Control byte view; field positions are visible to software
    typedef struct packed {
        logic [2:0]       rsvd;
        logic             unlock;
        logic             en;
        logic [SEL_W-1:0] sel;
    } wdt_ctl_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = run && !clr;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                tick  = 1'b0;
                if (clr || !run) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    cnt_d = '0;
                    tick  = 1'b1;
                end else begin
                    cnt_d = cnt_q + PW'(1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/wdt_period.sv
module wdt_period #(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int CW = BASE_EXP + (1 << SEL_W);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim    = (CW'(1) << (int'(sel) + BASE_EXP)) - CW'(1);
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (clr || !run) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q >= lim) begin
                cnt_d  = '0;
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic drop,
    output logic open
);
    localparam int UW = $clog2(CYCLES + 1);

    logic [UW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (arm)                cnt_d = UW'(CYCLES);
        else if (drop)          cnt_d = '0;
        else if (cnt_q != '0)   cnt_d = cnt_q - UW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign open = (cnt_q != '0);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int BASE_EXP      = 4,
    parameter int PRESCALE_DIV  = 16,
    parameter int UNLOCK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       kick,
    output logic [7:0] ctl_rdata,
    output logic       reset_req
);
    import wdt_pkg::*;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic             req;
    } wdt_state_t;

    wdt_state_t st_d, st_q;
    wdt_ctl_t   wr, rd;
    logic       arm, drop, win_open, start, clr, tick, expire;
    logic       unused_rsvd;

    assign wr          = wdt_ctl_t'(ctl_wdata);
    assign unused_rsvd = ^wr.rsvd;

    always_comb begin
        arm   = ctl_we && wr.en && wr.unlock;
        drop  = ctl_we && !wr.en && win_open;
        start = ctl_we && wr.en && !st_q.en;
        clr   = kick || start;

        st_d     = st_q;
        st_d.req = expire && !kick;
        if (ctl_we) begin
            st_d.sel = wr.sel;
            if (wr.en)          st_d.en = 1'b1;
            else if (win_open)  st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    wdt_unlock #(.CYCLES(UNLOCK_CYCLES)) u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .drop  (drop),
        .open  (win_open)
    );

    wdt_prescale #(.DIV(PRESCALE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.en),
        .clr   (clr),
        .tick  (tick)
    );

    wdt_period #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.en),
        .clr    (clr),
        .tick   (tick),
        .sel    (st_q.sel),
        .expire (expire)
    );

    always_comb begin
        rd        = '0;
        rd.unlock = win_open;
        rd.en     = st_q.en;
        rd.sel    = st_q.sel;
    end

    assign ctl_rdata = rd;
    assign reset_req = st_q.req;
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [7:0] ctl_wdata,
    input logic       kick,
    input logic [7:0] ctl_rdata,
    input logic       reset_req
);
    // R3: request lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R11: a request only follows a running cycle
    a_r11_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(ctl_rdata[3]));

    // R5: kick suppresses the next request
    a_r5_kick_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !reset_req);

    // R7 / R9: run bit only falls through a window write
    a_r7_stop_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rdata[3]) |-> $past(ctl_we && !ctl_wdata[3] && ctl_rdata[4]));

    // R8 / R10: window only opens on a combined write
    a_r10_window_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[4]) |-> $past(ctl_we && ctl_wdata[3] && ctl_wdata[4]));

    // R2: reserved bits read zero
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7:5] == 3'b000);
endmodule

bind wdt_core wdt_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .kick      (kick),
    .ctl_rdata (ctl_rdata),
    .reset_req (reset_req)
);

// File: tb/tb_wdt_core.sv
module tb_wdt_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       kick = 1'b0;
    logic [7:0] ctl_rdata;
    logic       reset_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wdt_core #(.BASE_EXP(2), .PRESCALE_DIV(2), .UNLOCK_CYCLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .kick(kick), .ctl_rdata(ctl_rdata), .reset_req(reset_req)
    );

    // {select[15:12], expected period in cycles[11:0]}
    localparam logic [15:0] VEC [0:4] = '{16'h0008, 16'h1010, 16'h2020, 16'h3040, 16'h7400};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; write edge is the next posedge; returns at the following negedge
    task automatic wr(input logic [7:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = 8'h00;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    // Edges from the last clearing edge until reset_req is seen high
    task automatic measure(output int n);
        n = 0;
        while (n < 4000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (reset_req) break;
        end
    endtask

    task automatic idle_count(input int cyc, output int seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (reset_req) seen++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", int'(ctl_rdata), 0);
        chk("R1 req", int'(reset_req), 0);
        idle_count(60, seen);
        chk("R11 stopped no req", seen, 0);

        // Table of periods
        for (int v = 0; v < 5; v++) begin
            logic [3:0]  s;
            logic [11:0] p;
            s = VEC[v][15:12];
            p = VEC[v][11:0];
            wr(8'h08 | {4'h0, s});
            chk("R2 readback", int'(ctl_rdata), int'(8'h08 | {4'h0, s}));
            do_kick();
            measure(n);
            chk("R3 period", n, int'(p));
            measure(n);
            chk("R4 restart period", n, int'(p));
        end

        // R7 stray stop write ignored (select 7 running)
        wr(8'h07);
        chk("R7 run kept", int'(ctl_rdata), 8'h0F);
        do_kick();
        measure(n);
        chk("R7 still times out", n, 1024);

        // R10 window bit without run bit
        wr(8'h17);
        chk("R10 no window", int'(ctl_rdata), 8'h0F);
        wr(8'h07);
        chk("R10 no stop", int'(ctl_rdata), 8'h0F);

        // R8 window length and self-clear; R9 late stop ignored
        wr(8'h1F);
        chk("R8 window open", int'(ctl_rdata), 8'h1F);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R8 window held", int'(ctl_rdata[4]), 1);
        end
        @(negedge clk);
        chk("R8 window closed", int'(ctl_rdata), 8'h0F);
        wr(8'h07);
        chk("R9 late stop ignored", int'(ctl_rdata), 8'h0F);

        // R9 stop on last edge inside the window
        wr(8'h1F);
        repeat (3) @(negedge clk);
        wr(8'h07);
        chk("R9 stop last edge", int'(ctl_rdata), 8'h07);
        idle_count(2100, seen);
        chk("R11 stopped no req", seen, 0);

        // R6 start from stopped clears count
        wr(8'h0F);
        measure(n);
        chk("R6 start period", n, 1024);

        // R9 stop on first edge of the window
        wr(8'h1F);
        wr(8'h06);
        chk("R9 stop first edge", int'(ctl_rdata), 8'h06);

        // R5 kicks hold off the request
        wr(8'h08);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            do_kick();
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                if (reset_req) seen++;
            end
        end
        chk("R5 kicks hold off", seen, 0);
        do_kick();
        measure(n);
        chk("R5 period after kick", n, 8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule